// File: doc/BRIEF.md
# Priority Pin Crossbar Decoder

This block decides at run time which port pin carries which internal peripheral signal. It serves a bank of three eight-pin ports that take part in routing, plus one trailing pin that only ever acts as general-purpose I/O. Nine peripheral groups, 23 signals in all, compete for the routable pins. A group enable vector turns groups on, and a skip mask withholds individual pins from routing. A priority walk then hands each enabled signal, from the highest-priority group down, the lowest-numbered pin that is neither skipped nor already taken.

Every pin gets an output value and an output enable. Each pin's drive style, push-pull or open-drain, comes from a per-pin mode bit. A pin that no signal claims drives its general-purpose latch bit. The level on each pad returns two ways: to the peripheral signal that owns the pad, and, one cycle later, to a port-read vector that does not depend on the routing.

Top module: `priority_xbar`

## Requirements
- R1: While reset is asserted and right after it, all mode bits are open-drain, every latch bit is 1, no group is enabled and no pin is skipped. So `padOut` and `padOe` are all 0, `sigIn` is all 1 and `portRead` is 0.
- R2: The configuration inputs (`cfgPeriphEn`, `cfgSkip`, `cfgPushPull`, `gpioData`) are captured on a clock edge. The outputs reflect a change only after the next rising edge, never in the same cycle.
- R3: The signal index sets the priority, index 0 highest. The groups are: bit 0 serial port A (signals 0-1), bit 1 SPI (2-5), bit 2 two-wire bus (6-7), bit 3 comparator A (8-9), bit 4 comparator B (10-11), bit 5 clock output (12), bit 6 capture/compare array (13-18), bit 7 timers (19-20), bit 8 serial port B (21-22). Enabled signals take the free pins in ascending pin order, in ascending signal order.
- R4: A pin whose `cfgSkip` bit is 1 is never given to a peripheral. The walk passes over it, and the pin behaves as general-purpose I/O.
- R5: When enabled signals outnumber the free pins, the lowest-priority extras stay unrouted and read 1 on `sigIn`. Every higher-priority placement is unchanged.
- R6: A routable pin that no signal claims drives its `gpioData` bit, with its source enable at 1.
- R7: The last pin (index 24) never carries a peripheral. It always behaves as general-purpose I/O.
- R8: For a pin whose `cfgPushPull` bit is 1, `padOut` is the source value and `padOe` is the source enable.
- R9: For a pin whose `cfgPushPull` bit is 0, `padOut` is 0 and `padOe` is 1 only when the source is enabled and its value is 0.
- R10: `sigIn` for a routed signal equals the pad level of its pin. For an unrouted signal it reads 1.
- R11: `portRead` equals `padIn` from the previous rising edge, whatever the routing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgPeriphEn | input | 9 | Group enables, bit g for group g |
| cfgSkip | input | 24 | Per routable pin: 1 keeps the pin out of routing |
| cfgPushPull | input | 25 | Per pin: 1 push-pull, 0 open-drain |
| gpioData | input | 25 | General-purpose output latch values |
| sigOut | input | 23 | Output value from each peripheral signal |
| sigOe | input | 23 | Output enable from each peripheral signal |
| sigIn | output | 23 | Pad level returned to each peripheral signal |
| padIn | input | 25 | Pad levels |
| padOut | output | 25 | Pad output value |
| padOe | output | 25 | Pad driver enable |
| portRead | output | 25 | Registered pad levels |

## Verification
The assertions assume that reset is released away from a clock edge and that `padIn` and the configuration are stable around each rising edge. Under those conditions, one-cycle `$past` relations describe the registered configuration exactly. They also assume at least one general-purpose-only pin is present. The bench changes every input on the falling edge and samples on the falling edge or one time unit after it, so each rising edge sees settled values. It releases reset on a falling edge.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  // Fixed peripheral population: nine groups, 23 signals in priority order.
  localparam int GROUPS    = 9;
  localparam int SIGS      = 23;
  localparam int SIG_SEL_W = $clog2(SIGS);

  // Per-pin strobe bundle from the control to the datapath.
  typedef struct packed {
    logic                 owned;
    logic [SIG_SEL_W-1:0] sel;
  } pinRoute_t;

  // Group owning a given signal index (group sizes 2,4,2,2,2,1,6,2,2).
  function automatic int groupOf(input int s);
    if (s < 2)       return 0;
    else if (s < 6)  return 1;
    else if (s < 8)  return 2;
    else if (s < 10) return 3;
    else if (s < 12) return 4;
    else if (s < 13) return 5;
    else if (s < 19) return 6;
    else if (s < 21) return 7;
    else             return 8;
  endfunction
endpackage

// File: rtl/xbar_ctrl.sv
module xbar_ctrl
  import xbar_pkg::*;
#(
  parameter int XPINS  = 24,
  parameter int RANK_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [GROUPS-1:0] cfgPeriphEn,
  input  logic [XPINS-1:0]  cfgSkip,
  output pinRoute_t         route [XPINS]
);

  logic [GROUPS-1:0] enReg;
  logic [XPINS-1:0]  skipReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg   <= '0;
      skipReg <= '0;
    end else begin
      enReg   <= cfgPeriphEn;
      skipReg <= cfgSkip;
    end
  end

  // Expand group enables to signal enables.
  logic [SIGS-1:0] sigEn;
  for (genvar gs = 0; gs < SIGS; gs++) begin : g_sigEn
    assign sigEn[gs] = enReg[groupOf(gs)];
  end

  // Rank of each enabled signal among the enabled ones.
  logic [RANK_W-1:0] sigRank [SIGS];
  always_comb begin : rankSig
    logic [RANK_W-1:0] acc;
    acc = '0;
    for (int s = 0; s < SIGS; s++) begin
      sigRank[s] = acc;
      if (sigEn[s]) acc = acc + RANK_W'(1);
    end
  end

  // Rank of each free pin among the free ones.
  logic [RANK_W-1:0] pinRank [XPINS];
  always_comb begin : rankPin
    logic [RANK_W-1:0] acc;
    acc = '0;
    for (int p = 0; p < XPINS; p++) begin
      pinRank[p] = acc;
      if (!skipReg[p]) acc = acc + RANK_W'(1);
    end
  end

  // Equal ranks pair the k-th enabled signal with the k-th free pin.
  always_comb begin
    for (int p = 0; p < XPINS; p++) begin
      route[p].owned = 1'b0;
      route[p].sel   = '0;
      for (int s = 0; s < SIGS; s++) begin
        if (!skipReg[p] && sigEn[s] && (sigRank[s] == pinRank[p])) begin
          route[p].owned = 1'b1;
          route[p].sel   = SIG_SEL_W'(s);
        end
      end
    end
  end

endmodule

// File: rtl/xbar_dpath.sv
module xbar_dpath
  import xbar_pkg::*;
#(
  parameter int XPINS = 24,
  parameter int NPIN  = 25
) (
  input  logic            clk,
  input  logic            rstN,
  input  pinRoute_t       route [XPINS],
  input  logic [NPIN-1:0] cfgPushPull,
  input  logic [NPIN-1:0] gpioData,
  input  logic [SIGS-1:0] sigOut,
  input  logic [SIGS-1:0] sigOe,
  output logic [SIGS-1:0] sigIn,
  input  logic [NPIN-1:0] padIn,
  output logic [NPIN-1:0] padOut,
  output logic [NPIN-1:0] padOe,
  output logic [NPIN-1:0] portRead
);

  logic [NPIN-1:0] ppReg;
  logic [NPIN-1:0] latchReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ppReg    <= '0;
      latchReg <= '1;
      portRead <= '0;
    end else begin
      ppReg    <= cfgPushPull;
      latchReg <= gpioData;
      portRead <= padIn;
    end
  end

  // Source value and enable per pin.
  logic [NPIN-1:0] srcD;
  logic [NPIN-1:0] srcE;
  always_comb begin
    for (int p = 0; p < XPINS; p++) begin
      if (route[p].owned) begin
        srcD[p] = sigOut[route[p].sel];
        srcE[p] = sigOe[route[p].sel];
      end else begin
        srcD[p] = latchReg[p];
        srcE[p] = 1'b1;
      end
    end
    for (int p = XPINS; p < NPIN; p++) begin
      srcD[p] = latchReg[p];
      srcE[p] = 1'b1;
    end
  end

  // Output stage: open-drain only ever pulls low.
  assign padOut = ppReg & srcD;
  assign padOe  = srcE & (ppReg | ~srcD);

  // Return path: owned pad level, idle high otherwise.
  always_comb begin
    sigIn = '1;
    for (int p = 0; p < XPINS; p++) begin
      if (route[p].owned) sigIn[route[p].sel] = padIn[p];
    end
  end

endmodule

// File: rtl/priority_xbar.sv
module priority_xbar
  import xbar_pkg::*;
#(
  parameter int XPORTS    = 3,
  parameter int PORT_W    = 8,
  parameter int GPIO_ONLY = 1
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [GROUPS-1:0]                 cfgPeriphEn,
  input  logic [XPORTS*PORT_W-1:0]          cfgSkip,
  input  logic [XPORTS*PORT_W+GPIO_ONLY-1:0] cfgPushPull,
  input  logic [XPORTS*PORT_W+GPIO_ONLY-1:0] gpioData,
  input  logic [SIGS-1:0]                   sigOut,
  input  logic [SIGS-1:0]                   sigOe,
  output logic [SIGS-1:0]                   sigIn,
  input  logic [XPORTS*PORT_W+GPIO_ONLY-1:0] padIn,
  output logic [XPORTS*PORT_W+GPIO_ONLY-1:0] padOut,
  output logic [XPORTS*PORT_W+GPIO_ONLY-1:0] padOe,
  output logic [XPORTS*PORT_W+GPIO_ONLY-1:0] portRead
);

  localparam int XPINS  = XPORTS * PORT_W;
  localparam int NPIN   = XPINS + GPIO_ONLY;
  localparam int RANK_W = $clog2((XPINS > SIGS ? XPINS : SIGS) + 1);

  pinRoute_t        route [XPINS];
  logic [XPINS-1:0] routeOwned;

  for (genvar gp = 0; gp < XPINS; gp++) begin : g_owned
    assign routeOwned[gp] = route[gp].owned;
  end

  xbar_ctrl #(.XPINS(XPINS), .RANK_W(RANK_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .cfgPeriphEn (cfgPeriphEn),
    .cfgSkip     (cfgSkip),
    .route       (route)
  );

  xbar_dpath #(.XPINS(XPINS), .NPIN(NPIN)) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .route       (route),
    .cfgPushPull (cfgPushPull),
    .gpioData    (gpioData),
    .sigOut      (sigOut),
    .sigOe       (sigOe),
    .sigIn       (sigIn),
    .padIn       (padIn),
    .padOut      (padOut),
    .padOe       (padOe),
    .portRead    (portRead)
  );

endmodule

// File: rtl/xbar_checker.sv
module xbar_checker
  import xbar_pkg::*;
#(
  parameter int XPINS = 24,
  parameter int NPIN  = 25
) (
  input logic              clk,
  input logic              rstN,
  input logic [GROUPS-1:0] cfgPeriphEn,
  input logic [XPINS-1:0]  cfgSkip,
  input logic [NPIN-1:0]   cfgPushPull,
  input logic [NPIN-1:0]   gpioData,
  input logic [NPIN-1:0]   padIn,
  input logic [NPIN-1:0]   padOut,
  input logic [NPIN-1:0]   padOe,
  input logic [SIGS-1:0]   sigIn,
  input logic [NPIN-1:0]   portRead,
  input logic [XPINS-1:0]  routeOwned
);

  // R9: an open-drain pin never drives a high value
  a_r9_open_drain_low: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((~$past(cfgPushPull)) & padOut) == '0);

  // R11: port read is the pad level one edge earlier
  a_r11_read_follows_pad: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> portRead == $past(padIn));

  // R4: a skipped pin is never owned by a peripheral
  a_r4_skip_unowned: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (routeOwned & $past(cfgSkip)) == '0);

  // R7: the last pin behaves purely from its latch bit
  a_r7_last_pin_gpio: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (padOut[NPIN-1] == ($past(cfgPushPull[NPIN-1]) & $past(gpioData[NPIN-1])))
          && (padOe[NPIN-1]  == ($past(cfgPushPull[NPIN-1]) | ~$past(gpioData[NPIN-1]))));

  // R10: with no group enabled every returned signal idles high
  a_r10_idle_high: assert property (@(posedge clk) disable iff (!rstN)
    (cfgPeriphEn == '0) |=> (sigIn == '1));

endmodule

bind priority_xbar xbar_checker #(.XPINS(XPINS), .NPIN(NPIN)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .cfgPeriphEn (cfgPeriphEn),
  .cfgSkip     (cfgSkip),
  .cfgPushPull (cfgPushPull),
  .gpioData    (gpioData),
  .padIn       (padIn),
  .padOut      (padOut),
  .padOe       (padOe),
  .sigIn       (sigIn),
  .portRead    (portRead),
  .routeOwned  (routeOwned)
);

// File: tb/sim_priority_xbar.sv
`timescale 1ns/1ps
module sim_priority_xbar;
  localparam real CLK_NS = 8.0;   // 125 MHz
  localparam int  NG = 9, NS = 23, NX = 24, NP = 25;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NG-1:0] cfgPeriphEn = '0;
  logic [NX-1:0] cfgSkip = '0;
  logic [NP-1:0] cfgPushPull = '0;
  logic [NP-1:0] gpioData = '1;
  logic [NS-1:0] sigOut = '0, sigOe = '0;
  logic [NS-1:0] sigIn;
  logic [NP-1:0] padIn = '0;
  logic [NP-1:0] padOut, padOe, portRead;

  // Configuration the design holds after the last applied edge.
  logic [NG-1:0] aEn = '0;
  logic [NX-1:0] aSkip = '0;
  logic [NP-1:0] aPp = '0;
  logic [NP-1:0] aLatch = '1;

  int nChk = 0, nBad = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  priority_xbar u0 (.*);

  function automatic int grp(input int s);
    case (s)
      0, 1:                   return 0;
      2, 3, 4, 5:             return 1;
      6, 7:                   return 2;
      8, 9:                   return 3;
      10, 11:                 return 4;
      12:                     return 5;
      13, 14, 15, 16, 17, 18: return 6;
      19, 20:                 return 7;
      default:                return 8;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected outputs from a sequential walk over pins (R3..R10).
  task automatic model(input logic [NG-1:0] en, input logic [NX-1:0] sk,
                       input logic [NP-1:0] pp, input logic [NP-1:0] lt,
                       output logic [NP-1:0] eOut, output logic [NP-1:0] eOe,
                       output logic [NS-1:0] eSig);
    int ptr = 0;
    eSig = '1;
    for (int p = 0; p < NP; p++) begin
      logic d, e;
      d = lt[p];
      e = 1'b1;
      if (p < NX && !sk[p]) begin
        while (ptr < NS && !en[grp(ptr)]) ptr++;
        if (ptr < NS) begin
          d = sigOut[ptr];
          e = sigOe[ptr];
          eSig[ptr] = padIn[p];
          ptr++;
        end
      end
      eOut[p] = pp[p] ? d : 1'b0;
      eOe[p]  = pp[p] ? e : (e & ~d);
    end
  endtask

  task automatic checkModel(input string tag);
    logic [NP-1:0] eo, ee;
    logic [NS-1:0] es;
    model(aEn, aSkip, aPp, aLatch, eo, ee, es);
    chk({tag, " padOut"}, 32'(padOut), 32'(eo));
    chk({tag, " padOe"},  32'(padOe),  32'(ee));
    chk({tag, " sigIn"},  32'(sigIn),  32'(es));
  endtask

  task automatic apply(input logic [NG-1:0] en, input logic [NX-1:0] sk,
                       input logic [NP-1:0] pp, input logic [NP-1:0] lt);
    @(negedge clk);
    cfgPeriphEn = en; cfgSkip = sk; cfgPushPull = pp; gpioData = lt;
    @(posedge clk);
    aEn = en; aSkip = sk; aPp = pp; aLatch = lt;
    @(negedge clk);
  endtask

  task automatic t_reset;
    #1;
    chk("R1 padOut in reset", 32'(padOut), 0);
    chk("R1 padOe in reset", 32'(padOe), 0);
    chk("R1 sigIn in reset", 32'(sigIn), 32'h7F_FFFF);
    chk("R1 portRead in reset", 32'(portRead), 0);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    chk("R1 padOe after reset", 32'(padOe), 0);
    chk("R1 padOut after reset", 32'(padOut), 0);
  endtask

  task automatic t_all_priority;
    sigOut = 23'h5A_3C96; sigOe = '1; padIn = 25'h0AA_55C3;
    apply('1, '0, '1, 25'h155_5555);
    checkModel("R3 all enabled");
    chk("R3 pin0 carries signal 0", 32'(padOut[0]), 32'(sigOut[0]));
    chk("R3 pin22 carries signal 22", 32'(padOut[22]), 32'(sigOut[22]));
    chk("R6 pin23 unclaimed uses latch", 32'(padOut[23]), 32'(gpioData[23]));
    chk("R8 pin23 push-pull oe", 32'(padOe[23]), 1);
  endtask

  task automatic t_subset;
    sigOut = 23'h7F_FFFF; sigOe = 23'h55_5555; padIn = 25'h000_03FF;
    apply(9'b0_0100_0010, '0, '1, '0);
    checkModel("R3 spi+array subset");
    chk("R3 spi at pins 0..3", 32'(padOe[3:0]), 32'({sigOe[5], sigOe[4], sigOe[3], sigOe[2]}));
    chk("R3 array at pins 4..9", 32'(padOe[9:4]), 32'(sigOe[18:13]));
    chk("R6 pin10 gpio", 32'({padOe[10], padOut[10]}), 32'(2'b10));
  endtask

  task automatic t_skip;
    sigOut = 23'h00_00C3; sigOe = '1; padIn = 25'h000_0030;
    apply(9'b0_0000_0101, 24'h00_0203, '1, '0);
    checkModel("R4 skip walk");
    chk("R4 skipped pin0 stays gpio", 32'(padOut[0]), 0);
    chk("R4 serial A on pins 2..3", 32'(padOut[3:2]), 32'(sigOut[1:0]));
    chk("R4 bus on pins 4..5", 32'(padOut[5:4]), 32'(sigOut[7:6]));
    chk("R10 bus returns pins 4..5", 32'(sigIn[7:6]), 32'(2'b11));
  endtask

  task automatic t_overflow;
    sigOut = 23'h2A_AAAA; sigOe = '1; padIn = '0;
    apply('1, 24'h01_0101, '1, '0);
    checkModel("R5 overflow");
    chk("R5 serial B unrouted reads 1", 32'(sigIn[22:21]), 3);
    chk("R5 routed signals see pads", 32'(sigIn[20:0]), 0);
    chk("R5 timers on last pins", 32'(padOut[23:22]), 32'(sigOut[20:19]));
  endtask

  task automatic t_open_drain;
    sigOut = 23'h12_3456; sigOe = 23'h7F_00FF; padIn = 25'h1FF_0000;
    apply(9'b1_1111_0000, 24'h80_0001, '0, 25'h0F0_F0F0);
    checkModel("R9 open drain");
    chk("R9 no pin driven high", 32'(padOut), 0);
  endtask

  task automatic t_last_pin;
    sigOut = '1; sigOe = '1;
    apply('1, '0, 25'h100_0000, 25'h000_0000);
    chk("R7 last pin low push-pull", 32'({padOe[24], padOut[24]}), 32'(2'b10));
    apply('1, '0, 25'h000_0000, 25'h100_0000);
    chk("R7 last pin released", 32'({padOe[24], padOut[24]}), 0);
  endtask

  task automatic t_return_path;
    apply(9'b0_0000_0001, '0, '1, '0);
    padIn = 25'h000_0001; #1;
    chk("R10 signal0 sees pin0 high", 32'(sigIn[1:0]), 1);
    padIn = 25'h000_0002; #1;
    chk("R10 signal1 sees pin1 high", 32'(sigIn[1:0]), 2);
    chk("R10 unrouted idle high", 32'(sigIn[22:2]), 32'h1F_FFFF);
  endtask

  task automatic t_port_read;
    apply('1, 24'hFF_FFFF, '1, '0);
    padIn = 25'h1AB_CDEF;
    #1;
    chk("R11 not yet captured", 32'(portRead), 32'h000_0002);
    @(negedge clk);
    chk("R11 captured after edge", 32'(portRead), 32'h1AB_CDEF);
  endtask

  task automatic t_latency;
    logic [NP-1:0] eo, ee;
    logic [NS-1:0] es;
    apply('0, '0, '1, '0);
    sigOut = '1; sigOe = '1;
    cfgPeriphEn = 9'h001; #1;
    chk("R2 old config before edge", 32'(padOut[1:0]), 0);
    @(posedge clk); aEn = 9'h001;
    @(negedge clk);
    model(aEn, aSkip, aPp, aLatch, eo, ee, es);
    chk("R2 new config after edge", 32'(padOut[1:0]), 32'(eo[1:0]));
    chk("R2 signal0 now on pin0", 32'(padOut[1:0]), 3);
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      nBad++; nChk++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_all_priority();
    t_subset();
    t_skip();
    t_overflow();
    t_open_drain();
    t_last_pin();
    t_return_path();
    t_port_read();
    t_latency();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule